// File: doc/BRIEF.md
# Indirect SDRAM configuration register block

This block holds the configuration and status registers of an SDRAM controller. Software reaches them through two device-control-register numbers. Writing the address port selects an internal register offset. A read or write of the data port then acts on the register that offset names. The register set covers:

- two write-one-to-clear bus-error status registers and a bus-error address register;
- a global configuration register and a read-only status register;
- a refresh timer and a power-management timer;
- a set of bank configuration registers;
- a timing register;
- an ECC configuration register and an ECC error status register.

The block also decodes a system address against the active banks. It gives a one-hot bank hit from each bank's base, size and valid bit, with all banks gated off while the controller is disabled. It drives an ECC error interrupt that is high exactly while the ECC error status register is nonzero. Driving the memory, refresh sequencing and ECC computation are done elsewhere.

Top module: `sdram_cfg_regs`

## Requirements
- R1: An access is accepted (`dcr_ack` high) only when `dcr_en` is high and `dcr_num` is the address port 0x10 or the data port 0x11. A write to the address port stores all 32 bits, and a read of the address port returns them. A data-port access acts on the register at the offset held in the address port. A read of any other control-register number returns 0 with `dcr_ack` low.
- R2: After reset, every register reads as follows:
  - address port, both bus-error status registers, bus-error address, status, ECC configuration and ECC error status: 0;
  - configuration: 0x00800000;
  - refresh timer: 0x05F00000;
  - power-management timer: 0x07C00000;
  - every bank register: 0.
  
  After reset, `ecc_irq` and `bank_hit` are 0.
- R3: The bus-error status registers sit at offsets 0x00 and 0x08. A write to either clears each bit written as 1 and leaves the other bits unchanged; both reset to 0. The bus-error address register at offset 0x10 stores the written value unchanged.
- R4: The configuration register sits at offset 0x20 and keeps only written bits 31:21.
  - When bit 31 (controller enable) changes from 0 to 1, every bank whose stored valid bit is set becomes active, and status bit 31 clears.
  - When bit 31 changes from 1 to 0, every bank becomes inactive, and status bit 31 sets.
- R5: The status register sits at offset 0x24.
  - A 0 to 1 change of configuration bit 30 sets status bit 30, and a 1 to 0 change clears it.
  - Status bits change at no other time.
  - A write to the status register has no effect.
- R6: The refresh timer at offset 0x30 stores the written value AND 0x3FF80000. The ECC configuration register at offset 0x94 stores the written value AND 0x00F00000. The power-management timer at offset 0x34 stores written bits 31:27 OR 0x07C00000.
- R7: Bank register i sits at offset 0x40 + 4*i and stores the written value AND 0xFFDEE001. Its fields are:
  - base: bits 31:23, on an 8 MiB granularity;
  - size code: bits 19:17, giving a size of 4 MiB shifted left by the code;
  - valid: bit 0.
- R8: A write to a bank register makes that bank active only if the written valid bit is 1 and the controller enable bit is already 1 at the time of the write. Otherwise the bank becomes inactive.
- R9: `bank_hit[i]` can be 1 only when all of the following hold:
  - the controller is enabled;
  - bank i is active;
  - the bank's size code is not 7;
  - base <= `probe_addr` < base + size.
  
  When several banks match, only the lowest-numbered one is reported, so `bank_hit` is always one-hot or zero.
- R10: The ECC error status register at offset 0x98 stores the written value AND 0xFFF0F000. `ecc_irq` rises in the cycle after a write takes it from zero to nonzero, and falls in the cycle after a write takes it back to zero.
- R11: A data-port read of the timing register (offset 0x80) or of any unassigned offset returns 0xFFFFFFFF. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dcr_en | input | 1 | Control-register access strobe |
| dcr_we | input | 1 | 1 = write, 0 = read |
| dcr_num | input | NUM_W | Control-register number |
| dcr_wdata | input | 32 | Write data |
| dcr_rdata | output | 32 | Read data (combinational) |
| dcr_ack | output | 1 | Access targets the address or data port |
| probe_addr | input | 32 | System address to decode |
| bank_hit | output | NBANK | One-hot bank match |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
On every cycle, the assertions check the following:
- the bank hit is one-hot or zero and is silent while the controller is disabled;
- status bits 31 and 30 follow the edges of configuration bits 31 and 30, and never move without one;
- the power-management timer's fixed bits hold;
- the interrupt matches the ECC error status being nonzero.

Some behaviours only the bench's scenarios can show:
- the register write masks and reset values;
- the write-to-clear action;
- the all-ones reads of the timing register and unassigned offsets;
- that a bank is active only when written while the controller is enabled;
- base and size bounds, the invalid size code and the priority of overlapping banks.

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs #(
  parameter int NUM_W = 10,
  parameter logic [NUM_W-1:0] ADDR_PORT = 10'h010,
  parameter logic [NUM_W-1:0] DATA_PORT = 10'h011,
  parameter int NBANK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dcr_en,
  input  logic             dcr_we,
  input  logic [NUM_W-1:0] dcr_num,
  input  logic [31:0]      dcr_wdata,
  output logic [31:0]      dcr_rdata,
  output logic             dcr_ack,
  input  logic [31:0]      probe_addr,
  output logic [NBANK-1:0] bank_hit,
  output logic             ecc_irq
);
  localparam logic [31:0] BANK_MASK = 32'hFFDEE001;
  localparam logic [31:0] BANK_OFF0 = 32'h40;

  logic [31:0] addr_q, besr0_q, besr1_q, bear_q, cfg_q, stat_q;
  logic [31:0] rtr_q, pmit_q, ecccfg_q, eccesr_q;
  logic [31:0] bcr_w [NBANK];
  logic [NBANK-1:0] act_w, raw_hit;
  logic irq_q;
  logic [31:0] data_rd;

  wire sel_a = dcr_en && (dcr_num == ADDR_PORT);
  wire sel_d = dcr_en && (dcr_num == DATA_PORT);
  wire wr_d  = sel_d && dcr_we;
  wire [31:0] cfg_new = dcr_wdata & 32'hFFE00000;
  wire cfg_wr = wr_d && (addr_q == 32'h20);
  wire en_up  = cfg_wr && !cfg_q[31] &&  cfg_new[31];
  wire en_dn  = cfg_wr &&  cfg_q[31] && !cfg_new[31];
  wire b30_up = cfg_wr && !cfg_q[30] &&  cfg_new[30];
  wire b30_dn = cfg_wr &&  cfg_q[30] && !cfg_new[30];
  wire [31:0] ecc_new = dcr_wdata & 32'hFFF0F000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      besr0_q  <= '0;
      besr1_q  <= '0;
      bear_q   <= '0;
      cfg_q    <= 32'h00800000;
      stat_q   <= '0;
      rtr_q    <= 32'h05F00000;
      pmit_q   <= 32'h07C00000;
      ecccfg_q <= '0;
      eccesr_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (sel_a && dcr_we) addr_q <= dcr_wdata;
      if (wr_d) begin
        case (addr_q)
          32'h00: besr0_q  <= besr0_q & ~dcr_wdata;
          32'h08: besr1_q  <= besr1_q & ~dcr_wdata;
          32'h10: bear_q   <= dcr_wdata;
          32'h20: cfg_q    <= cfg_new;
          32'h30: rtr_q    <= dcr_wdata & 32'h3FF80000;
          32'h34: pmit_q   <= (dcr_wdata & 32'hF8000000) | 32'h07C00000;
          32'h94: ecccfg_q <= dcr_wdata & 32'h00F00000;
          32'h98: begin
            eccesr_q <= ecc_new;
            irq_q    <= (ecc_new != 32'h0);
          end
          default: ;
        endcase
      end
      if (en_up) stat_q[31] <= 1'b0;
      else if (en_dn) stat_q[31] <= 1'b1;
      if (b30_up) stat_q[30] <= 1'b1;
      else if (b30_dn) stat_q[30] <= 1'b0;
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam logic [31:0] OFF = BANK_OFF0 + 32'(4 * g);
    logic [31:0] bcr_q;
    logic        act_q;
    wire bw = wr_d && (addr_q == OFF);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bcr_q <= '0;
        act_q <= 1'b0;
      end else if (bw) begin
        bcr_q <= dcr_wdata & BANK_MASK;
        act_q <= cfg_q[31] && dcr_wdata[0];
      end else if (en_up) begin
        act_q <= bcr_q[0];
      end else if (en_dn) begin
        act_q <= 1'b0;
      end
    end
    wire [2:0]  code = bcr_q[19:17];
    wire [32:0] lo   = {1'b0, bcr_q[31:23], 23'b0};
    wire [32:0] hi   = lo + (33'd4194304 << code);
    wire [32:0] pa   = {1'b0, probe_addr};
    assign bcr_w[g]   = bcr_q;
    assign act_w[g]   = act_q;
    assign raw_hit[g] = act_q && cfg_q[31] && (code != 3'd7) && (pa >= lo) && (pa < hi);
  end

  assign bank_hit = raw_hit & (~raw_hit + 1'b1);
  assign ecc_irq  = irq_q;

  always_comb begin
    data_rd = 32'hFFFFFFFF;
    case (addr_q)
      32'h00: data_rd = besr0_q;
      32'h08: data_rd = besr1_q;
      32'h10: data_rd = bear_q;
      32'h20: data_rd = cfg_q;
      32'h24: data_rd = stat_q;
      32'h30: data_rd = rtr_q;
      32'h34: data_rd = pmit_q;
      32'h94: data_rd = ecccfg_q;
      32'h98: data_rd = eccesr_q;
      default: ;
    endcase
    for (int i = 0; i < NBANK; i++)
      if (addr_q == BANK_OFF0 + 32'(4 * i)) data_rd = bcr_w[i];
  end

  assign dcr_ack   = sel_a || sel_d;
  assign dcr_rdata = sel_a ? addr_q : (sel_d ? data_rd : 32'h0);
endmodule

module sdram_cfg_regs_chk #(parameter int NBANK = 4) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_b30,
  input logic [1:0]       stat,
  input logic [31:0]      pmit,
  input logic [31:0]      eccesr,
  input logic             irq,
  input logic [NBANK-1:0] hit
);
  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit)); // R9
  AST_HIT_GATED: assert property (@(posedge clk) disable iff (!rst_n) !cfg_en |-> (hit == '0)); // R9
  AST_EN_CLEARS_STAT: assert property (@(posedge clk) disable iff (!rst_n) $rose(cfg_en) |-> !stat[1]); // R4
  AST_DIS_SETS_STAT: assert property (@(posedge clk) disable iff (!rst_n) $fell(cfg_en) |-> stat[1]); // R4
  AST_B30_UP: assert property (@(posedge clk) disable iff (!rst_n) $rose(cfg_b30) |-> stat[0]); // R5
  AST_B30_DOWN: assert property (@(posedge clk) disable iff (!rst_n) $fell(cfg_b30) |-> !stat[0]); // R5
  AST_STAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ($stable(cfg_en) && $stable(cfg_b30)) |-> $stable(stat)); // R5
  AST_PMIT_FIXED: assert property (@(posedge clk) disable iff (!rst_n) (pmit[26:22] == 5'h1F) && (pmit[21:0] == 22'h0)); // R6
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) irq == (eccesr != 32'h0)); // R10
endmodule

bind sdram_cfg_regs sdram_cfg_regs_chk #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_q[31]), .cfg_b30(cfg_q[30]),
  .stat(stat_q[31:30]), .pmit(pmit_q), .eccesr(eccesr_q), .irq(ecc_irq), .hit(bank_hit)
);

// File: tb/sdram_cfg_regs_bench.sv
`timescale 1ns/1ps
module sdram_cfg_regs_bench;
  logic clk = 0, rst_n = 0;
  logic dcr_en = 0, dcr_we = 0;
  logic [9:0] dcr_num = '0;
  logic [31:0] dcr_wdata = '0, probe_addr = '0;
  logic [31:0] dcr_rdata;
  logic dcr_ack, ecc_irq;
  logic [3:0] bank_hit;
  int checks = 0, fails = 0;
  bit live = 0;

  logic [31:0] m_addr, m_besr0, m_besr1, m_bear, m_cfg, m_stat, m_rtr, m_pmit, m_eccc, m_ecce;
  logic [31:0] m_bcr [4];
  bit m_act [4];
  bit m_irq;

  always #4 clk = ~clk;

  sdram_cfg_regs u_sdram_cfg_regs (
    .clk(clk), .rst_n(rst_n), .dcr_en(dcr_en), .dcr_we(dcr_we), .dcr_num(dcr_num),
    .dcr_wdata(dcr_wdata), .dcr_rdata(dcr_rdata), .dcr_ack(dcr_ack),
    .probe_addr(probe_addr), .bank_hit(bank_hit), .ecc_irq(ecc_irq));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] m_hit(logic [31:0] a);
    for (int i = 0; i < 4; i++) begin
      longint base = longint'(m_bcr[i] & 32'hFF800000);
      int code = int'(m_bcr[i][19:17]);
      if (m_cfg[31] && m_act[i] && code != 7 && longint'(a) >= base &&
          longint'(a) < base + (longint'(4194304) << code))
        return 4'(1 << i);
    end
    return 4'h0;
  endfunction

  function automatic logic [31:0] m_read(logic [31:0] off);
    case (off)
      32'h00: return m_besr0;
      32'h08: return m_besr1;
      32'h10: return m_bear;
      32'h20: return m_cfg;
      32'h24: return m_stat;
      32'h30: return m_rtr;
      32'h34: return m_pmit;
      32'h40: return m_bcr[0];
      32'h44: return m_bcr[1];
      32'h48: return m_bcr[2];
      32'h4C: return m_bcr[3];
      32'h94: return m_eccc;
      32'h98: return m_ecce;
      default: return 32'hFFFFFFFF;
    endcase
  endfunction

  task automatic m_write(logic [31:0] v);
    logic [31:0] c;
    case (m_addr)
      32'h00: m_besr0 &= ~v;
      32'h08: m_besr1 &= ~v;
      32'h10: m_bear = v;
      32'h20: begin
        c = v & 32'hFFE00000;
        if (!m_cfg[31] && c[31]) begin
          m_stat[31] = 0;
          for (int i = 0; i < 4; i++) m_act[i] = m_bcr[i][0];
        end else if (m_cfg[31] && !c[31]) begin
          m_stat[31] = 1;
          for (int i = 0; i < 4; i++) m_act[i] = 0;
        end
        if (!m_cfg[30] && c[30]) m_stat[30] = 1;
        else if (m_cfg[30] && !c[30]) m_stat[30] = 0;
        m_cfg = c;
      end
      32'h30: m_rtr = v & 32'h3FF80000;
      32'h34: m_pmit = (v & 32'hF8000000) | 32'h07C00000;
      32'h40, 32'h44, 32'h48, 32'h4C: begin
        m_bcr[(m_addr - 32'h40) >> 2] = v & 32'hFFDEE001;
        m_act[(m_addr - 32'h40) >> 2] = m_cfg[31] && v[0];
      end
      32'h94: m_eccc = v & 32'h00F00000;
      32'h98: begin m_ecce = v & 32'hFFF0F000; m_irq = (m_ecce != 0); end
      default: ;
    endcase
  endtask

  task automatic wport(logic [9:0] num, logic [31:0] v);
    @(negedge clk);
    dcr_en = 1; dcr_we = 1; dcr_num = num; dcr_wdata = v;
    @(posedge clk); #1;
    dcr_en = 0; dcr_we = 0;
    if (num == 10'h010) m_addr = v;
    else if (num == 10'h011) m_write(v);
  endtask

  task automatic wreg(logic [31:0] off, logic [31:0] v);
    wport(10'h010, off);
    wport(10'h011, v);
  endtask

  task automatic rport(string tag, logic [9:0] num, logic [31:0] exp, logic exp_ack);
    @(negedge clk);
    dcr_en = 1; dcr_we = 0; dcr_num = num;
    #1;
    check(tag, dcr_rdata, exp);
    check(tag, {31'b0, dcr_ack}, {31'b0, exp_ack});
    dcr_en = 0;
  endtask

  task automatic rreg(string tag, logic [31:0] off);
    wport(10'h010, off);
    rport(tag, 10'h011, m_read(off), 1'b1);
  endtask

  task automatic probe(string tag, logic [31:0] a, logic [3:0] exp);
    @(negedge clk);
    probe_addr = a;
    #1;
    check(tag, {28'b0, bank_hit}, {28'b0, exp});
    check(tag, {28'b0, m_hit(a)}, {28'b0, exp});
  endtask

  always @(negedge clk) begin
    #2;
    if (live) begin
      check("R9 per-cycle hit", {28'b0, bank_hit}, {28'b0, m_hit(probe_addr)});
      check("R10 per-cycle irq", {31'b0, ecc_irq}, {31'b0, m_irq});
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_addr = 0; m_besr0 = 0; m_besr1 = 0; m_bear = 0; m_cfg = 32'h00800000; m_stat = 0;
    m_rtr = 32'h05F00000; m_pmit = 32'h07C00000; m_eccc = 0; m_ecce = 0; m_irq = 0;
    for (int i = 0; i < 4; i++) begin m_bcr[i] = 0; m_act[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    live = 1;
    // R2 reset state
    rport("R2 addr reset", 10'h010, 32'h0, 1'b1);
    check("R2 irq reset", {31'b0, ecc_irq}, 32'h0);
    check("R2 hit reset", {28'b0, bank_hit}, 32'h0);
    rreg("R2 cfg reset", 32'h20);
    check("R2 cfg value", m_cfg, 32'h00800000);
    rreg("R2 stat reset", 32'h24);
    rreg("R2 rtr reset", 32'h30);
    rreg("R2 pmit reset", 32'h34);
    rreg("R2 besr0 reset", 32'h00);
    rreg("R2 ecc reset", 32'h98);
    rreg("R2 bank reset", 32'h44);
    // R1 address port and foreign numbers
    wport(10'h010, 32'hCAFE0034);
    rport("R1 addr readback", 10'h010, 32'hCAFE0034, 1'b1);
    rport("R1 foreign num", 10'h012, 32'h0, 1'b0);
    // R3 clear-on-write and plain address register
    wreg(32'h00, 32'hFFFFFFFF);
    rreg("R3 besr0", 32'h00);
    wreg(32'h08, 32'h0F0F0F0F);
    rreg("R3 besr1", 32'h08);
    wreg(32'h10, 32'h12345678);
    rreg("R3 bear", 32'h10);
    // R7 bank mask
    wreg(32'h4C, 32'hFFFFFFFF);
    rreg("R7 bank mask", 32'h4C);
    check("R7 bank mask value", m_bcr[3], 32'hFFDEE001);
    wreg(32'h4C, 32'h0);
    // R8 bank written while disabled is not active
    wreg(32'h40, 32'h00020001);
    probe("R8 disabled no hit", 32'h00100000, 4'h0);
    // R4 enable edge: status bit 31 clears, bit 30 sets (R5)
    wreg(32'h20, 32'hFFFFFFFF);
    rreg("R4 cfg mask", 32'h20);
    rreg("R5 status after enable", 32'h24);
    check("R5 status value", m_stat, 32'h40000000);
    probe("R8 enable activates valid bank", 32'h00100000, 4'h1);
    probe("R9 end bound", 32'h00800000, 4'h0);
    probe("R9 last byte", 32'h007FFFFF, 4'h1);
    wreg(32'h44, 32'h00800001);
    probe("R9 bank1 hit", 32'h00900000, 4'h2);
    wreg(32'h48, 32'h020E0001);
    probe("R9 invalid size code", 32'h02000000, 4'h0);
    wreg(32'h4C, 32'h00000001);
    probe("R9 overlap priority", 32'h00100000, 4'h1);
    wreg(32'h40, 32'h00020000);
    probe("R8 invalid write deactivates", 32'h00100000, 4'h8);
    // R5 status ignores writes
    wreg(32'h24, 32'hFFFFFFFF);
    rreg("R5 status read-only", 32'h24);
    // R4 disable edge
    wreg(32'h20, 32'h00000000);
    rreg("R4 status after disable", 32'h24);
    check("R4 status value", m_stat, 32'h80000000);
    probe("R4 disabled drops mappings", 32'h00900000, 4'h0);
    wreg(32'h20, 32'h80000000);
    probe("R4 re-enable restores valid bank", 32'h00900000, 4'h2);
    rreg("R4 status after re-enable", 32'h24);
    // R6 masks
    wreg(32'h30, 32'hFFFFFFFF);
    rreg("R6 rtr mask", 32'h30);
    wreg(32'h34, 32'h00000000);
    rreg("R6 pmit fixed bits", 32'h34);
    wreg(32'h34, 32'hFFFFFFFF);
    rreg("R6 pmit high", 32'h34);
    wreg(32'h94, 32'hFFFFFFFF);
    rreg("R6 ecc cfg mask", 32'h94);
    // R10 ECC error status and interrupt
    wreg(32'h98, 32'hFFFFFFFF);
    rreg("R10 ecc mask", 32'h98);
    check("R10 irq high", {31'b0, ecc_irq}, 32'h1);
    wreg(32'h98, 32'h000F0F00);
    rreg("R10 masked to zero", 32'h98);
    check("R10 irq low", {31'b0, ecc_irq}, 32'h0);
    // R11 timing register and unassigned offsets
    wreg(32'h80, 32'h0);
    rreg("R11 timing reads ones", 32'h80);
    wreg(32'h50, 32'h0);
    rreg("R11 unassigned reads ones", 32'h50);
    rreg("R11 bear untouched", 32'h10);
    rreg("R11 bank0 untouched", 32'h40);
    repeat (4) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule